// File: doc/BRIEF.md
# RTC Register Domain Crossing

This block sits between a fast bus clock and a slow timekeeping clock of a real-time counter. Software writes the counter value, two compare values, a prescale setting and a write-one-to-clear flag register on the bus side. The block keeps shadow copies there and moves them into the slow domain through a toggle request and acknowledge handshake. The data bundle is held stable on the bus side while the toggle crosses a two-flop synchronizer. A sync-pending status bit stays high from the bus cycle after a qualifying write until the slow side has applied every queued value.

Writes to the counter and to the prescale field are carried across on their own. Compare writes only update the shadow copy. They reach the slow domain when a later flag-register write asks to clear any of the low five flag bits. In the slow domain a counter advances once every 2^n slow cycles, where n is the prescale field. Increment, wrap and compare-match events travel back to the bus side with a snapshot of the counter over a second handshake. Flag bits are set from those events, and counter reads return the snapshot.

Top module: `rtc_cdc_regs`

## Requirements
- R1: After reset every readable register reads zero, pending_o is 0, rtc_cnt_o is 0 and the prescale field is 0.
- R2: A write to address 0 (counter) sets pending_o in the next bus cycle. When pending_o falls, rtc_cnt_o equals the written value.
- R3: Writes made while a transfer is pending are queued, not dropped. After pending_o falls, the slow side holds the last value written to each register.
- R4: A write to address 1 (compare 0) or address 2 (compare 1) leaves pending_o low if it was low. It does not change the slow-side compare until a trigger arrives.
- R5: A write to address 3 (flags) with any of wdata_i[4:0] set transfers both compare shadows and sets pending_o in the next bus cycle, even when no flag is set. A flag write with wdata_i[4:0] zero starts no transfer.
- R6: A write to address 4 takes wdata_i[3:0] as prescale n and is transferred like a counter write. The counter then advances once every 2^n slow cycles, and loading it clears the divider.
- R7: The slow counter steps by exactly one per prescale period and wraps from all ones to zero.
- R8: Flag bit 0 sets when the counter steps onto compare 0. Bit 1 does the same for compare 1. Bit 2 sets on a wrap, bit 3 on every step and bit 4 when a bus-to-slow transfer completes. Writing 1 to a bit clears it, and a set in the same cycle wins.
- R9: A read of address 0 returns a counter snapshot delivered through a handshake. Once the counter is stopped the snapshot equals rtc_cnt_o. A read of address 3 returns the flags in bits [4:0] and pending in bit 8.
- R10: rtc_match_o[k] is high in the slow domain while the counter equals the applied compare k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rtc_clk_i | input | 1 | Slow timekeeping clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| pending_o | output | 1 | Transfer to slow domain queued or in flight |
| rtc_cnt_o | output | CNT_W | Slow-domain counter |
| rtc_match_o | output | 2 | Counter equals compare 1 / compare 0 |

## Verification
pending_o is due exactly one bus cycle after the write edge, so the bench samples it at the falling edge that follows each write. The slow-side effect of a transfer is in place when pending_o drops, because the acknowledge is sent from the same slow edge that applies the data. The bench therefore waits for pending_o with a bounded poll and then checks rtc_cnt_o and rtc_match_o. Snapshot reads and flag events need a few slow cycles to return, so those checks follow a fixed margin of ten to twenty slow cycles. Counting rates are measured between falling edges of the slow clock over whole prescale periods.

// File: rtl/rtc_sync_pkg.sv
package rtc_sync_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 5;
  localparam int NEVT   = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT   = 3'd0,
    A_CMP0  = 3'd1,
    A_CMP1  = 3'd2,
    A_FLAG  = 3'd3,
    A_PRESC = 3'd4
  } reg_addr_e;

  // load-select bits in a transfer bundle
  localparam int LD_CNT   = 0;
  localparam int LD_CMP   = 1;
  localparam int LD_PRESC = 2;
  localparam int NLD      = 3;

  localparam int PEND_BIT = 8;
endpackage

// File: rtl/rtc_bit_sync.sv
module rtc_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rtc_bus_side.sv
module rtc_bus_side
  import rtc_sync_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [CNT_W-1:0]        wdata_i,
  output logic [CNT_W-1:0]        rdata_o,
  output logic                    pending_o,
  output logic                    req_tgl_o,
  output logic [CNT_W-1:0]        x_cnt_o,
  output logic [CNT_W-1:0]        x_cmp0_o,
  output logic [CNT_W-1:0]        x_cmp1_o,
  output logic [PRESC_W-1:0]      x_presc_o,
  output logic [NLD-1:0]          x_ld_o,
  input  logic                    ack_tgl_i,
  input  logic                    snap_tgl_i,
  input  logic [CNT_W-1:0]        snap_cnt_i,
  input  logic [NEVT-1:0]         snap_evt_i,
  output logic                    snap_ack_o
);
  logic [CNT_W-1:0]   cnt_wr_q, cmp0_q, cmp1_q, cnt_rd_q;
  logic [PRESC_W-1:0] presc_q;
  logic [NLD-1:0]     dirty_q, dirty_set;
  logic [NFLAG-1:0]   flags_q, flag_clr, evt_all;
  logic req_q, ack_s, ack_prev_q, busy, launch;
  logic snap_s, snap_seen_q, new_snap;
  logic wr_cnt, wr_cmp0, wr_cmp1, wr_flag, wr_presc;

  rtc_bit_sync #(.W(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_tgl_i, snap_tgl_i}),
    .q_o   ({ack_s, snap_s})
  );

  assign wr_cnt   = we_i && (addr_i == A_CNT);
  assign wr_cmp0  = we_i && (addr_i == A_CMP0);
  assign wr_cmp1  = we_i && (addr_i == A_CMP1);
  assign wr_flag  = we_i && (addr_i == A_FLAG);
  assign wr_presc = we_i && (addr_i == A_PRESC);

  always_comb begin
    dirty_set           = '0;
    dirty_set[LD_CNT]   = wr_cnt;
    dirty_set[LD_CMP]   = wr_flag && (wdata_i[NFLAG-1:0] != '0);
    dirty_set[LD_PRESC] = wr_presc;
  end

  assign busy      = req_q ^ ack_s;
  assign launch    = !busy && (dirty_q != '0);
  assign pending_o = busy || (dirty_q != '0);
  assign new_snap  = snap_s ^ snap_seen_q;
  assign flag_clr  = wr_flag ? wdata_i[NFLAG-1:0] : '0;
  assign evt_all   = {ack_s ^ ack_prev_q, new_snap ? snap_evt_i : {NEVT{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_wr_q    <= '0;
      cmp0_q      <= '0;
      cmp1_q      <= '0;
      presc_q     <= '0;
      dirty_q     <= '0;
      req_q       <= 1'b0;
      ack_prev_q  <= 1'b0;
      x_cnt_o     <= '0;
      x_cmp0_o    <= '0;
      x_cmp1_o    <= '0;
      x_presc_o   <= '0;
      x_ld_o      <= '0;
      snap_seen_q <= 1'b0;
      cnt_rd_q    <= '0;
      flags_q     <= '0;
    end else begin
      if (wr_cnt)   cnt_wr_q <= wdata_i;
      if (wr_cmp0)  cmp0_q   <= wdata_i;
      if (wr_cmp1)  cmp1_q   <= wdata_i;
      if (wr_presc) presc_q  <= wdata_i[PRESC_W-1:0];
      // bundle stays frozen until the acknowledge returns
      if (launch) begin
        x_cnt_o   <= cnt_wr_q;
        x_cmp0_o  <= cmp0_q;
        x_cmp1_o  <= cmp1_q;
        x_presc_o <= presc_q;
        x_ld_o    <= dirty_q;
        req_q     <= ~req_q;
      end
      dirty_q    <= (launch ? '0 : dirty_q) | dirty_set;
      ack_prev_q <= ack_s;
      if (new_snap) begin
        cnt_rd_q    <= snap_cnt_i;
        snap_seen_q <= snap_s;
      end
      flags_q <= (flags_q & ~flag_clr) | evt_all;
    end
  end

  assign req_tgl_o  = req_q;
  assign snap_ack_o = snap_seen_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CNT:   rdata_o = cnt_rd_q;
      A_CMP0:  rdata_o = cmp0_q;
      A_CMP1:  rdata_o = cmp1_q;
      A_FLAG: begin
        rdata_o[NFLAG-1:0] = flags_q;
        rdata_o[PEND_BIT]  = pending_o;
      end
      A_PRESC: rdata_o = CNT_W'(presc_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_tick_side.sv
module rtc_tick_side
  import rtc_sync_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_tgl_i,
  input  logic [CNT_W-1:0]   x_cnt_i,
  input  logic [CNT_W-1:0]   x_cmp0_i,
  input  logic [CNT_W-1:0]   x_cmp1_i,
  input  logic [PRESC_W-1:0] x_presc_i,
  input  logic [NLD-1:0]     x_ld_i,
  output logic               ack_tgl_o,
  output logic               snap_tgl_o,
  output logic [CNT_W-1:0]   snap_cnt_o,
  output logic [NEVT-1:0]    snap_evt_o,
  input  logic               snap_ack_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [1:0]         match_o
);
  localparam int DIV_W = (1 << PRESC_W) - 1;

  logic [CNT_W-1:0]   cnt_q, cmp0_q, cmp1_q, cnt_inc;
  logic [DIV_W-1:0]   div_q, mask;
  logic [PRESC_W-1:0] presc_q;
  logic [NEVT-1:0]    evt_q, evt_new;
  logic req_s, req_seen_q, apply, load_cnt, tick, step;
  logic snap_ack_s, snap_q, send;

  rtc_bit_sync #(.W(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({req_tgl_i, snap_ack_i}),
    .q_o   ({req_s, snap_ack_s})
  );

  assign apply    = req_s ^ req_seen_q;
  assign load_cnt = apply && x_ld_i[LD_CNT];
  assign mask     = ~({DIV_W{1'b1}} << presc_q);
  assign tick     = (div_q == mask);
  assign step     = tick && !load_cnt;
  assign cnt_inc  = cnt_q + 1'b1;

  always_comb begin
    evt_new    = '0;
    evt_new[0] = step && (cnt_inc == cmp0_q);
    evt_new[1] = step && (cnt_inc == cmp1_q);
    evt_new[2] = step && (cnt_q == '1);
    evt_new[3] = step;
  end

  assign send = (snap_q == snap_ack_s) && ((snap_cnt_o != cnt_q) || (evt_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      div_q      <= '0;
      cmp0_q     <= '0;
      cmp1_q     <= '0;
      presc_q    <= '0;
      req_seen_q <= 1'b0;
      evt_q      <= '0;
      snap_q     <= 1'b0;
      snap_cnt_o <= '0;
      snap_evt_o <= '0;
    end else begin
      if (tick) begin
        div_q <= '0;
        cnt_q <= cnt_inc;
      end else begin
        div_q <= div_q + 1'b1;
      end
      if (apply) begin
        req_seen_q <= req_s;
        if (x_ld_i[LD_CNT]) begin
          cnt_q <= x_cnt_i;
          div_q <= '0;
        end
        if (x_ld_i[LD_CMP]) begin
          cmp0_q <= x_cmp0_i;
          cmp1_q <= x_cmp1_i;
        end
        if (x_ld_i[LD_PRESC]) begin
          presc_q <= x_presc_i;
          div_q   <= '0;
        end
      end
      if (send) begin
        snap_cnt_o <= cnt_q;
        snap_evt_o <= evt_q;
        snap_q     <= ~snap_q;
      end
      evt_q <= (send ? '0 : evt_q) | evt_new;
    end
  end

  assign ack_tgl_o  = req_seen_q;
  assign snap_tgl_o = snap_q;
  assign cnt_o      = cnt_q;
  assign match_o    = {cnt_q == cmp1_q, cnt_q == cmp0_q};
endmodule

// File: rtl/rtc_cdc_regs.sv
module rtc_cdc_regs
  import rtc_sync_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 4
) (
  input  logic              clk_i,
  input  logic              rtc_clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              pending_o,
  output logic [CNT_W-1:0]  rtc_cnt_o,
  output logic [1:0]        rtc_match_o
);
  logic               req_tgl, ack_tgl, snap_tgl, snap_ack;
  logic [CNT_W-1:0]   x_cnt, x_cmp0, x_cmp1, snap_cnt;
  logic [PRESC_W-1:0] x_presc;
  logic [NLD-1:0]     x_ld;
  logic [NEVT-1:0]    snap_evt;

  rtc_bus_side #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) i_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pending_o (pending_o),
    .req_tgl_o (req_tgl),
    .x_cnt_o   (x_cnt),
    .x_cmp0_o  (x_cmp0),
    .x_cmp1_o  (x_cmp1),
    .x_presc_o (x_presc),
    .x_ld_o    (x_ld),
    .ack_tgl_i (ack_tgl),
    .snap_tgl_i(snap_tgl),
    .snap_cnt_i(snap_cnt),
    .snap_evt_i(snap_evt),
    .snap_ack_o(snap_ack)
  );

  rtc_tick_side #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) i_tick (
    .clk_i     (rtc_clk_i),
    .rst_ni    (rst_ni),
    .req_tgl_i (req_tgl),
    .x_cnt_i   (x_cnt),
    .x_cmp0_i  (x_cmp0),
    .x_cmp1_i  (x_cmp1),
    .x_presc_i (x_presc),
    .x_ld_i    (x_ld),
    .ack_tgl_o (ack_tgl),
    .snap_tgl_o(snap_tgl),
    .snap_cnt_o(snap_cnt),
    .snap_evt_o(snap_evt),
    .snap_ack_i(snap_ack),
    .cnt_o     (rtc_cnt_o),
    .match_o   (rtc_match_o)
  );
endmodule

// File: rtl/rtc_cdc_regs_chk.sv
module rtc_cdc_regs_chk
  import rtc_sync_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rtc_clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              pending_o,
  input logic [CNT_W-1:0]  rtc_cnt_o,
  input logic              cnt_load,
  input logic              flag0,
  input logic              evt0
);
  p_pend_after_cnt_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CNT) |=> pending_o);

  p_cmp_wr_no_xfer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && we_i && (addr_i == A_CMP0 || addr_i == A_CMP1)) |=> !pending_o);

  p_flag_trig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FLAG && wdata_i[NFLAG-1:0] != '0) |=> pending_o);

  p_flag_noop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && we_i && addr_i == A_FLAG && wdata_i[NFLAG-1:0] == '0) |=> !pending_o);

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FLAG && wdata_i[0] && !evt0) |=> !flag0);

  p_cnt_step_r7: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    !cnt_load |=> (rtc_cnt_o == $past(rtc_cnt_o) || rtc_cnt_o == $past(rtc_cnt_o) + 1'b1));
endmodule

bind rtc_cdc_regs rtc_cdc_regs_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rtc_clk_i(rtc_clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pending_o(pending_o),
  .rtc_cnt_o(rtc_cnt_o),
  .cnt_load (i_tick.load_cnt),
  .flag0    (i_bus.flags_q[0]),
  .evt0     (i_bus.evt_all[0])
);

// File: tb/test_rtc_cdc_regs.sv
module test_rtc_cdc_regs;
  localparam int CNT_W = 32;

  logic             clk = 1'b0, rtc_clk = 1'b0, rst_n = 1'b0;
  logic             we = 1'b0;
  logic [2:0]       addr = '0;
  logic [CNT_W-1:0] wdata = '0, rdata, rtc_cnt;
  logic             pending;
  logic [1:0]       match;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always #85 rtc_clk = ~rtc_clk;

  rtc_cdc_regs #(.CNT_W(CNT_W), .PRESC_W(4)) i_rtc_cdc_regs (
    .clk_i(clk), .rtc_clk_i(rtc_clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pending_o(pending), .rtc_cnt_o(rtc_cnt),
    .rtc_match_o(match)
  );

  task automatic chk(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [CNT_W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [CNT_W-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle(string req);
    for (int i = 0; i < 400 && pending; i++) @(negedge clk);
    chk({req, " pending clears"}, CNT_W'(pending), '0);
  endtask

  task automatic slow_wait(int n);
    repeat (n) @(negedge rtc_clk);
  endtask

  task automatic t_reset;
    logic [CNT_W-1:0] v;
    chk("R1 pending", CNT_W'(pending), '0);
    chk("R1 rtc_cnt", rtc_cnt, '0);
    bus_rd(3'd0, v); chk("R1 cnt read", v, '0);
    bus_rd(3'd3, v); chk("R1 flags", v, '0);
    bus_rd(3'd4, v); chk("R1 presc", v, '0);
  endtask

  task automatic t_cnt_load;
    logic [CNT_W-1:0] v;
    bus_wr(3'd4, 32'd15);
    chk("R6 pending on presc write", CNT_W'(pending), 1);
    wait_idle("R6");
    bus_wr(3'd0, 32'h100);
    chk("R2 pending after cnt write", CNT_W'(pending), 1);
    wait_idle("R2");
    chk("R2 slow counter loaded", rtc_cnt, 32'h100);
    slow_wait(20);
    bus_rd(3'd0, v); chk("R9 snapshot read", v, 32'h100);
    bus_rd(3'd3, v); chk("R8 done flag bit4", CNT_W'(v[4]), 1);
  endtask

  task automatic t_cmp_stage;
    logic [CNT_W-1:0] v;
    bus_wr(3'd1, 32'h100);
    chk("R4 no pending on cmp write", CNT_W'(pending), '0);
    slow_wait(10);
    chk("R4 cmp not applied", CNT_W'(match[0]), '0);
    bus_wr(3'd3, 32'h100);
    chk("R5 zero low bits no trigger", CNT_W'(pending), '0);
    slow_wait(10);
    chk("R5 cmp still not applied", CNT_W'(match[0]), '0);
    bus_wr(3'd3, 32'h1);
    chk("R5 trigger raises pending", CNT_W'(pending), 1);
    wait_idle("R5");
    slow_wait(2);
    chk("R10 match after trigger", CNT_W'(match[0]), 1);
    bus_rd(3'd1, v); chk("R4 cmp0 read", v, 32'h100);
  endtask

  task automatic t_queue;
    bus_wr(3'd0, 32'h11);
    bus_wr(3'd0, 32'h22);
    chk("R3 pending while queued", CNT_W'(pending), 1);
    bus_wr(3'd2, 32'h22);
    bus_wr(3'd3, 32'h10);
    wait_idle("R3");
    chk("R3 last cnt applied", rtc_cnt, 32'h22);
    slow_wait(2);
    chk("R3 cmp1 applied", CNT_W'(match[1]), 1);
    chk("R10 cmp0 no match", CNT_W'(match[0]), '0);
  endtask

  task automatic t_rate;
    logic [CNT_W-1:0] a;
    bus_wr(3'd4, 32'd0);
    wait_idle("R7");
    slow_wait(1);
    a = rtc_cnt;
    slow_wait(5);
    chk("R7 one step per slow cycle", rtc_cnt - a, 32'd5);
    bus_wr(3'd4, 32'd2);
    wait_idle("R6");
    slow_wait(1);
    a = rtc_cnt;
    slow_wait(8);
    chk("R6 divide by 4", rtc_cnt - a, 32'd2);
  endtask

  task automatic t_match_flag;
    logic [CNT_W-1:0] v;
    bus_wr(3'd4, 32'd15);
    wait_idle("R8");
    bus_wr(3'd0, 32'h200);
    bus_wr(3'd1, 32'h203);
    wait_idle("R8");
    slow_wait(10);
    bus_wr(3'd3, 32'h1f);
    wait_idle("R8");
    bus_wr(3'd4, 32'd0);
    wait_idle("R8");
    slow_wait(20);
    bus_rd(3'd3, v);
    chk("R8 cmp0 flag", CNT_W'(v[0]), 1);
    chk("R8 cmp1 flag clear", CNT_W'(v[1]), '0);
    chk("R8 step flag", CNT_W'(v[3]), 1);
    bus_wr(3'd3, 32'h1);
    bus_rd(3'd3, v);
    chk("R8 w1c bit0", CNT_W'(v[0]), '0);
  endtask

  task automatic t_wrap;
    logic [CNT_W-1:0] v;
    bus_wr(3'd4, 32'd15);
    wait_idle("R7");
    bus_wr(3'd0, 32'hffff_fffd);
    wait_idle("R7");
    slow_wait(10);
    bus_wr(3'd3, 32'h1f);
    wait_idle("R7");
    bus_wr(3'd4, 32'd0);
    wait_idle("R7");
    slow_wait(12);
    bus_rd(3'd3, v);
    chk("R8 wrap flag", CNT_W'(v[2]), 1);
    chk("R7 wrapped low", CNT_W'(rtc_cnt < 32'h20), 1);
  endtask

  task automatic t_stop_read;
    logic [CNT_W-1:0] v;
    bus_wr(3'd4, 32'd15);
    wait_idle("R9");
    slow_wait(20);
    bus_rd(3'd0, v);
    chk("R9 snapshot equals counter", v, rtc_cnt);
    bus_rd(3'd3, v);
    chk("R9 pending bit8 idle", CNT_W'(v[8]), '0);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    slow_wait(3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cnt_load();
    t_cmp_stage();
    t_queue();
    t_rate();
    t_match_flag();
    t_wrap();
    t_stop_read();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule